// File: doc/BRIEF.md
# Packed-Pixel Video Serializer

This block turns 16-bit words fetched from video memory into a stream of RGB pixels, one pixel per clock, for a video mode in which every pixel carries its own colour instead of being assembled from bitplanes. There is no palette lookup: the colour code in memory goes straight to the channel drivers. A mode input picks one of two packings. In word mode a whole word is one pixel with 4 bits per channel. In byte mode a word holds two pixels, each with a 2-bit code per channel and one intensity bit shared by all three channels, which widens each channel to 3 bits.

Words arrive through a valid/ready handshake, and the serializer pulls a new word only when the pixels of the current one are used up. A display-enable input marks the visible part of the line: while it is low the output shows a border colour input and any half-used word is dropped. If a word is needed and none is offered, the pixel shows the border colour and an underrun flag is raised for that pixel.

Control is a two-state machine. ST_WANT means the next pixel needs a fresh word; ST_HOLD means the low byte of a byte-mode word is still to be shown. Transitions: ST_WANT to ST_HOLD when a word is accepted in byte mode; ST_WANT to ST_WANT when a word is accepted in word mode, on an underrun, or while display-enable is low; ST_HOLD to ST_WANT on every cycle (the held byte is either shown or, with display-enable low, dropped).

Top module: `chunky_pix_serializer`

## Requirements
- R1: During and straight after reset `rgb_o` is 0, `underrun_o` is 0 and the state is ST_WANT, so `word_ready_o` is high as soon as `de_i` is high.
- R2: In word mode (`mode_i` = 1) an accepted word gives one pixel with red = word bits 11:8, green = bits 7:4, blue = bits 3:0; bits 15:12 are ignored, and `word_ready_o` stays high on every display-enabled cycle.
- R3: In byte mode (`mode_i` = 0) a byte is laid out bit 7..0 as R1 R0 G1 G0 B1 B0 unused I; each output channel is the 3-bit value {code, I} in bits 2:0 of its 4-bit field with bit 3 zero, and bit 1 has no effect; byte 0x01 gives 1/1/1 (dim grey), 0xFC gives 6/6/6 (light grey), 0xFD gives 7/7/7 (white).
- R4: In byte mode the high byte (word bits 15:8) is shown first and the low byte on the following clock; `word_ready_o` is low during the low-byte cycle.
- R5: A pixel reaches `rgb_o` at the clock edge that accepts its word (a single output register), and the low byte one edge later.
- R6: While `de_i` is low, `word_ready_o` is low, and at the next edge `rgb_o` takes `border_i` with `underrun_o` low.
- R7: A low byte still pending when `de_i` goes low is discarded; the next display-enabled cycle requests a new word.
- R8: When a word is needed (`word_ready_o` high) and `word_valid_i` is low, the pixel is `border_i` and `underrun_o` is high for that one pixel; a low-byte cycle never raises `underrun_o`.
- R9: A held low byte is shown with the byte-mode expansion even if `mode_i` changes to word mode on its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = two pixels per word (byte mode), 1 = one pixel per word |
| de_i | input | 1 | Display enable; low selects the border colour |
| word_i | input | 16 | Pixel word from video memory |
| word_valid_i | input | 1 | `word_i` holds a word |
| word_ready_o | output | 1 | Serializer takes `word_i` at this edge if valid |
| border_i | input | 12 | Border colour, 4 bits per channel, red in the top nibble |
| rgb_o | output | 12 | Pixel colour, red 11:8, green 7:4, blue 3:0 |
| underrun_o | output | 1 | Pixel was needed but no word was offered |

## Verification
The hardest case to reach is display-enable dropping in the very cycle a low byte is pending, since the source must first have a byte-mode word accepted and then blank on the next edge; the bench places a blanking cycle right after such an acceptance and then checks that the following visible pixel comes from a fresh word. A mode switch exactly on the held-byte cycle is reached the same way. The colour mapping is covered by sweeping every 12-bit word-mode value and every byte in both the high and low position of a word.

// File: rtl/chunky_pkg.sv
package chunky_pkg;

    typedef enum logic {
        ST_WANT = 1'b0,
        ST_HOLD = 1'b1
    } cps_state_e;

    localparam logic MODE_BYTE = 1'b0;
    localparam logic MODE_WORD = 1'b1;

endpackage

// File: rtl/cps_byte_expand.sv
module cps_byte_expand #(
    parameter int CODE_W = 2,
    parameter int CH_W   = 4,
    localparam int BYTE_W = 3 * CODE_W + 2,
    localparam int RGB_W  = 3 * CH_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [RGB_W-1:0]  rgb_o
);

    for (genvar c = 0; c < 3; c++) begin : g_chan
        localparam int SRC_HI = BYTE_W - 1 - c * CODE_W;
        localparam int DST_HI = RGB_W - 1 - c * CH_W;
        assign rgb_o[DST_HI -: CH_W] = CH_W'({byte_i[SRC_HI -: CODE_W], byte_i[0]});
    end

    logic unused_spare_bit;
    assign unused_spare_bit = byte_i[1];

endmodule

// File: rtl/cps_word_unpack.sv
module cps_word_unpack #(
    parameter int CH_W = 4,
    localparam int RGB_W = 3 * CH_W
) (
    input  logic [RGB_W-1:0] field_i,
    output logic [RGB_W-1:0] rgb_o
);

    for (genvar c = 0; c < 3; c++) begin : g_chan
        localparam int HI = RGB_W - 1 - c * CH_W;
        assign rgb_o[HI -: CH_W] = field_i[HI -: CH_W];
    end

endmodule

// File: rtl/chunky_pix_serializer.sv
module chunky_pix_serializer
    import chunky_pkg::*;
#(
    parameter int CODE_W = 2,
    parameter int CH_W   = 4,
    localparam int BYTE_W = 3 * CODE_W + 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int RGB_W  = 3 * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              de_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    input  logic [RGB_W-1:0]  border_i,
    output logic [RGB_W-1:0]  rgb_o,
    output logic              underrun_o
);

    cps_state_e        st_q, st_d;
    logic [BYTE_W-1:0] low_q;
    logic              take;
    logic [RGB_W-1:0]  hi_rgb, lo_rgb, wd_rgb;
    logic [RGB_W-1:0]  pix_d;
    logic              under_d;

    cps_byte_expand #(.CODE_W(CODE_W), .CH_W(CH_W)) u_hi (
        .byte_i (word_i[WORD_W-1 -: BYTE_W]),
        .rgb_o  (hi_rgb)
    );

    cps_byte_expand #(.CODE_W(CODE_W), .CH_W(CH_W)) u_lo (
        .byte_i (low_q),
        .rgb_o  (lo_rgb)
    );

    cps_word_unpack #(.CH_W(CH_W)) u_word (
        .field_i (word_i[RGB_W-1:0]),
        .rgb_o   (wd_rgb)
    );

    // Handshake and next state
    always_comb begin
        word_ready_o = de_i && (st_q == ST_WANT);
        take         = word_ready_o && word_valid_i;
        st_d         = ST_WANT;
        unique case (st_q)
            ST_WANT: begin
                if (take && mode_i == MODE_BYTE) st_d = ST_HOLD;
                else                             st_d = ST_WANT;
            end
            ST_HOLD: st_d = ST_WANT;
            default: st_d = ST_WANT;
        endcase
    end

    // Pixel selection
    always_comb begin
        pix_d   = border_i;
        under_d = 1'b0;
        if (de_i) begin
            unique case (st_q)
                ST_WANT: begin
                    if (take) begin
                        pix_d = (mode_i == MODE_BYTE) ? hi_rgb : wd_rgb;
                    end else begin
                        under_d = 1'b1;
                    end
                end
                ST_HOLD: pix_d = lo_rgb;
                default: pix_d = border_i;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WANT;
            low_q <= '0;
        end else begin
            st_q <= st_d;
            if (take && mode_i == MODE_BYTE) begin
                low_q <= word_i[BYTE_W-1:0];
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_o      <= '0;
            underrun_o <= 1'b0;
        end else begin
            rgb_o      <= pix_d;
            underrun_o <= under_d;
        end
    end

endmodule

// File: rtl/chunky_pix_serializer_chk.sv
module chunky_pix_serializer_chk #(
    parameter int CODE_W = 2,
    parameter int CH_W   = 4,
    localparam int BYTE_W = 3 * CODE_W + 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int RGB_W  = 3 * CH_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              de_i,
    input logic [WORD_W-1:0] word_i,
    input logic              word_valid_i,
    input logic              word_ready_o,
    input logic [RGB_W-1:0]  border_i,
    input logic [RGB_W-1:0]  rgb_o,
    input logic              underrun_o
);

    p_blank_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |-> !word_ready_o);

    p_blank_pix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |=> (rgb_o == $past(border_i) && !underrun_o));

    p_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready_o && !word_valid_i) |=> (underrun_o && rgb_o == $past(border_i)));

    p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> $past(word_ready_o && !word_valid_i));

    p_word_pix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready_o && word_valid_i && mode_i) |=> rgb_o == $past(word_i[RGB_W-1:0]));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready_o && word_valid_i && !mode_i) |=> !word_ready_o);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de_i && !word_ready_o) |=> (word_ready_o || !de_i));

endmodule

bind chunky_pix_serializer chunky_pix_serializer_chk #(
    .CODE_W(CODE_W),
    .CH_W  (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .de_i         (de_i),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .border_i     (border_i),
    .rgb_o        (rgb_o),
    .underrun_o   (underrun_o)
);

// File: tb/chunky_pix_serializer_tb.sv
module chunky_pix_serializer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b1;
    logic        de_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        word_valid_i = 1'b0;
    logic        word_ready_o;
    logic [11:0] border_i = '0;
    logic [11:0] rgb_o;
    logic        underrun_o;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    logic rdy_seen;

    always #2 clk = ~clk;

    chunky_pix_serializer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .de_i         (de_i),
        .word_i       (word_i),
        .word_valid_i (word_valid_i),
        .word_ready_o (word_ready_o),
        .border_i     (border_i),
        .rgb_o        (rgb_o),
        .underrun_o   (underrun_o)
    );

    function automatic logic [11:0] exp_byte(input int b);
        int i, r, g, bl;
        i  = b & 1;
        r  = ((b >> 6) & 3) * 2 + i;
        g  = ((b >> 4) & 3) * 2 + i;
        bl = ((b >> 2) & 3) * 2 + i;
        return 12'(r * 256 + g * 16 + bl);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, note ready, then step past the edge.
    task automatic drive(input logic de, input logic v, input logic [15:0] w,
                         input logic m, input logic [11:0] bd);
        de_i = de; word_valid_i = v; word_i = w; mode_i = m; border_i = bd;
        #1;
        rdy_seen = word_ready_o;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset rgb", 32'(rgb_o), 32'h0);
        chk("R1 reset underrun", 32'(underrun_o), 32'h0);
        rst_n = 1'b1;

        // R1/R8: first visible cycle, no word offered -> underrun with border
        drive(1, 0, 16'h0, 1, 12'h5A3);
        chk("R1 ready after reset", 32'(rdy_seen), 32'h1);
        chk("R8 underrun pixel", 32'(rgb_o), 32'h5A3);
        chk("R8 underrun flag", 32'(underrun_o), 32'h1);

        // R2/R5: word mode sweep over every 12-bit colour
        for (int i = 0; i < 4096; i++) begin
            drive(1, 1, {4'(~i), 12'(i)}, 1, 12'hFFF);
            chk("R2 word ready", 32'(rdy_seen), 32'h1);
            chk("R2 R5 word pixel", 32'(rgb_o), 32'(i));
            chk("R8 no underrun word", 32'(underrun_o), 32'h0);
        end

        // R3/R4: byte mode, every byte in high and low position
        for (int b = 0; b < 256; b++) begin
            drive(1, 1, {8'(b), 8'(b ^ 8'hA5)}, 0, 12'h000);
            chk("R4 byte ready high", 32'(rdy_seen), 32'h1);
            chk("R3 R4 high byte", 32'(rgb_o), 32'(exp_byte(b)));
            drive(1, 1, 16'hDEAD, 0, 12'h000);
            chk("R4 ready low on low byte", 32'(rdy_seen), 32'h0);
            chk("R3 R4 low byte", 32'(rgb_o), 32'(exp_byte(b ^ 8'hA5)));
            chk("R8 no underrun low byte", 32'(underrun_o), 32'h0);
        end

        // R3: named greys, bit 1 ignored
        drive(1, 1, 16'h01FC, 0, 12'h000);
        chk("R3 dim grey", 32'(rgb_o), 32'h111);
        drive(1, 0, 16'h0, 0, 12'h000);
        chk("R3 light grey", 32'(rgb_o), 32'h666);
        drive(1, 1, 16'hFDFF, 0, 12'h000);
        chk("R3 white", 32'(rgb_o), 32'h777);
        drive(1, 1, 16'h0, 0, 12'h000);
        chk("R3 spare bit ignored", 32'(rgb_o), 32'h777);

        // R8: held low byte with no word valid -> no underrun
        drive(1, 1, 16'h4080, 0, 12'hABC);
        drive(1, 0, 16'h0, 0, 12'hABC);
        chk("R8 hold no underrun", 32'(underrun_o), 32'h0);
        chk("R8 hold pixel", 32'(rgb_o), 32'(exp_byte(8'h80)));

        // R6/R7: blank while low byte pending, pending byte dropped
        drive(1, 1, 16'hC030, 0, 12'h000);
        chk("R7 high byte before blank", 32'(rgb_o), 32'(exp_byte(8'hC0)));
        drive(0, 1, 16'h1111, 0, 12'h9E2);
        chk("R6 ready low blank", 32'(rdy_seen), 32'h0);
        chk("R6 border pixel", 32'(rgb_o), 32'h9E2);
        chk("R6 no underrun blank", 32'(underrun_o), 32'h0);
        drive(1, 1, 16'h0C81, 0, 12'h000);
        chk("R7 new word requested", 32'(rdy_seen), 32'h1);
        chk("R7 pending byte dropped", 32'(rgb_o), 32'(exp_byte(8'h0C)));
        drive(1, 0, 16'h0, 0, 12'h000);
        chk("R7 low of new word", 32'(rgb_o), 32'(exp_byte(8'h81)));

        // R6: border sweep while blanked
        for (int k = 0; k < 16; k++) begin
            drive(0, 1, 16'hFFFF, 1, 12'(k * 273));
            chk("R6 border sweep", 32'(rgb_o), 32'(k * 273));
        end

        // R9: mode flips to word mode on the held-byte cycle
        drive(1, 1, 16'h3C55, 0, 12'h000);
        drive(1, 1, 16'h0FFF, 1, 12'h000);
        chk("R9 held byte keeps byte mapping", 32'(rgb_o), 32'(exp_byte(8'h55)));
        drive(1, 1, 16'h0123, 1, 12'h000);
        chk("R9 word mode resumes", 32'(rgb_o), 32'h123);

        // R8: underrun in word mode, one pixel only
        drive(1, 0, 16'h0, 1, 12'h4D4);
        chk("R8 word underrun flag", 32'(underrun_o), 32'h1);
        chk("R8 word underrun pixel", 32'(rgb_o), 32'h4D4);
        drive(1, 1, 16'h0777, 1, 12'h4D4);
        chk("R8 underrun clears", 32'(underrun_o), 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule